// File: doc/BRIEF.md
# Quad Core Special-Wakeup Register Block

This block holds the hypervisor special-wakeup requests for a group of four cores. Software reaches it over a 64-bit, word-addressed register bus. A write to the request register names its target cores through a four-bit select field inside the word offset, not through the data word. Any mix of cores can therefore be woken or released with a single write to one logical register. The most significant data bit gives the level that each selected core's wakeup flag takes. The same bit also sets or clears one completion flag shared by the whole group.

The four stored flags drive the per-core wakeup outputs with no further logic. Completion is treated as immediate. A read of the status register reports two "done" bits whenever the shared flag is set. Address decode ignores the core-select field, so the status register answers at every value of that field. Other offsets, and every access narrower than 64 bits, read as all ones. Writes to those offsets, and narrow writes, change nothing.

Top module: `quad_wakeup_regs`

## Requirements
- R1: After reset, and again after any later reset, all four wakeup outputs and the shared done flag are 0, and no read response is pending.
- R2: Offset bits 15..12 (LSB-first numbering of the 32-bit word offset) are masked out before decode. The status register at masked offset 0x82C answers for every value of those bits.
- R3: A 64-bit write to masked offset 0x83C (the request register) sets the shared done flag to data bit 63 (LSB-first). No other data bit has any effect.
- R4: In the same write, the flag of core i (i = 0..3) takes the value of data bit 63 when offset bit 15-i is 1. Core 0 is selected by bit 15 and core 3 by bit 12.
- R5: In a request write, a core whose select bit is 0 keeps its previous flag.
- R6: A 64-bit read of masked offset 0x82C returns 0x4800_0000_0000_0000 (bits 62 and 59 set) when the done flag is set, and returns 0 otherwise.
- R7: A read of any other offset, including the request offset, returns all ones. Writes to offsets other than the request offset change neither the flags nor the outputs.
- R8: An access with bus_wide low is not a supported width. Such a write changes nothing, and such a read returns all ones.
- R9: A read answers with bus_rvalid high and bus_rdata valid exactly one cycle after the request. bus_rvalid stays low after writes and idle cycles.
- R10: core_wake[i] equals core i's stored flag, so it changes in the clock edge that accepts the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | 1 = 64-bit access (the only supported width) |
| bus_off | input | 32 | Word offset; bits 15..12 select cores |
| bus_wdata | input | 64 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| bus_rdata | output | 64 | Read data |
| core_wake | output | 4 | Per-core special-wakeup level |

## Verification
The bench targets the bit-ordering traps. It writes data whose low bits are all set while the top bit is clear, and it selects single cores by individual offset bits. A design that read the wrong data bit, or that reversed the core order, would raise the wrong output. It reads the status register with all four select bits set. A design that left the select field in the decode would return all ones there. It also issues writes with no core selected, writes to an unimplemented offset that carries select bits, and narrow accesses. A design that let any of these through would clear the done flag or move a wakeup output.

// File: rtl/qwk_pkg.sv
package qwk_pkg;
   // Convert an MSB-first bit index into an LSB-first index for a word of w bits.
   function automatic int msb0(input int w, input int idx);
      return w - 1 - idx;
   endfunction
endpackage

// File: rtl/qwk_addr_dec.sv
module qwk_addr_dec #(
   parameter int          AW       = 32,
   parameter int          NCORES   = 4,
   parameter int          SEL_LSB  = 12,
   parameter logic [31:0] REQ_OFF  = 32'h0000_083C,
   parameter logic [31:0] STAT_OFF = 32'h0000_082C
) (
   input  logic              req,
   input  logic              we,
   input  logic              wide,
   input  logic [AW-1:0]     off,
   output logic              wr_req,
   output logic              rd_en,
   output logic              rd_stat,
   output logic [NCORES-1:0] sel
);
   localparam logic [AW-1:0] SEL_FIELD = AW'({NCORES{1'b1}}) << SEL_LSB;
   localparam logic [AW-1:0] REQ_A     = REQ_OFF[AW-1:0];
   localparam logic [AW-1:0] STAT_A    = STAT_OFF[AW-1:0];

   if (SEL_LSB + NCORES > AW) begin : g_bad_sel
      $error("core-select field does not fit in the offset");
   end
   if ((REQ_A & SEL_FIELD) != '0 || (STAT_A & SEL_FIELD) != '0) begin : g_bad_off
      $error("register offsets overlap the core-select field");
   end

   logic [AW-1:0] masked;
   assign masked  = off & ~SEL_FIELD;
   assign wr_req  = req && we && wide && (masked == REQ_A);
   assign rd_en   = req && !we;
   assign rd_stat = wide && (masked == STAT_A);

   // The highest select bit maps to core 0.
   for (genvar i = 0; i < NCORES; i++) begin : g_sel
      assign sel[i] = off[SEL_LSB + NCORES - 1 - i];
   end
endmodule

// File: rtl/qwk_flag_bank.sv
module qwk_flag_bank #(
   parameter int NCORES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_val,
   input  logic [NCORES-1:0] sel,
   output logic [NCORES-1:0] wake,
   output logic              done
);
   if (NCORES < 1) begin : g_bad_n
      $error("NCORES must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     done <= 1'b0;
      else if (wr_en) done <= wr_val;
   end

   for (genvar i = 0; i < NCORES; i++) begin : g_core
      always_ff @(posedge clk) begin
         if (!rst_n)                wake[i] <= 1'b0;
         else if (wr_en && sel[i])  wake[i] <= wr_val;
      end

      // R4
      sel_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && sel[i]) |=> (wake[i] == $past(wr_val)));
      // R5
      unsel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !(wr_en && sel[i]) |=> $stable(wake[i]));
   end

   // R3
   done_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (done == $past(wr_val)));
endmodule

// File: rtl/qwk_read_port.sv
module qwk_read_port #(
   parameter int DW     = 64,
   parameter int ST_A   = 1,
   parameter int ST_B   = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_en,
   input  logic          rd_stat,
   input  logic          done,
   output logic          rvalid,
   output logic [DW-1:0] rdata
);
   import qwk_pkg::*;

   localparam int            IA        = msb0(DW, ST_A);
   localparam int            IB        = msb0(DW, ST_B);
   localparam logic [DW-1:0] STAT_WORD = (DW'(1) << IA) | (DW'(1) << IB);

   if (ST_A >= DW || ST_B >= DW || ST_A == ST_B) begin : g_bad_bits
      $error("status bit positions invalid");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rvalid <= 1'b0;
         rdata  <= '0;
      end else begin
         rvalid <= rd_en;
         if (rd_en) rdata <= rd_stat ? (done ? STAT_WORD : '0) : '1;
      end
   end

   // R9
   rvalid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rvalid);
   // R9
   rvalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rvalid);
   // R6
   stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_stat && !done) |=> (rdata == '0));
   // R7
   unimpl_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !rd_stat) |=> (rdata == '1));
endmodule

// File: rtl/quad_wakeup_regs.sv
module quad_wakeup_regs #(
   parameter int          AW       = 32,
   parameter int          DW       = 64,
   parameter int          NCORES   = 4,
   parameter int          SEL_LSB  = 12,
   parameter logic [31:0] REQ_OFF  = 32'h0000_083C,
   parameter logic [31:0] STAT_OFF = 32'h0000_082C,
   parameter int          REQ_BIT  = 0,
   parameter int          ST_A     = 1,
   parameter int          ST_B     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic              bus_we,
   input  logic              bus_wide,
   input  logic [AW-1:0]     bus_off,
   input  logic [DW-1:0]     bus_wdata,
   output logic              bus_rvalid,
   output logic [DW-1:0]     bus_rdata,
   output logic [NCORES-1:0] core_wake
);
   import qwk_pkg::*;

   localparam int REQ_IDX = msb0(DW, REQ_BIT);

   if (REQ_BIT >= DW) begin : g_bad_req
      $error("request bit outside data word");
   end

   logic              wr_req, rd_en, rd_stat, done;
   logic [NCORES-1:0] sel;

   qwk_addr_dec #(
      .AW(AW), .NCORES(NCORES), .SEL_LSB(SEL_LSB),
      .REQ_OFF(REQ_OFF), .STAT_OFF(STAT_OFF)
   ) u_dec (
      .req(bus_req), .we(bus_we), .wide(bus_wide), .off(bus_off),
      .wr_req(wr_req), .rd_en(rd_en), .rd_stat(rd_stat), .sel(sel)
   );

   qwk_flag_bank #(.NCORES(NCORES)) u_flags (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_req),
      .wr_val(bus_wdata[REQ_IDX]), .sel(sel),
      .wake(core_wake), .done(done)
   );

   qwk_read_port #(.DW(DW), .ST_A(ST_A), .ST_B(ST_B)) u_rd (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_stat(rd_stat),
      .done(done), .rvalid(bus_rvalid), .rdata(bus_rdata)
   );

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |=> (core_wake == '0 && !bus_rvalid));
   // R8
   narrow_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_we && !bus_wide) |=> $stable(core_wake));
   // R7
   other_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_we && !wr_req) |=> $stable(core_wake));
endmodule

// File: tb/quad_wakeup_regs_bench.sv
module quad_wakeup_regs_bench;
   localparam logic [63:0] ONES = '1;
   localparam logic [63:0] SW   = 64'h4800_0000_0000_0000;
   localparam logic [63:0] D1   = 64'h8000_0000_0000_0000;
   localparam logic [63:0] D0   = 64'h0;

   typedef struct packed {
      logic        we;
      logic        wide;
      logic [31:0] off;
      logic [63:0] wd;
      logic [3:0]  ew;
      logic [63:0] er;
      logic [3:0]  rq;
   } vec_t;

   localparam int NV = 19;
   localparam vec_t TBL [NV] = '{
      '{1'b0, 1'b1, 32'h082C, D0, 4'b0000, D0, 4'd6},              // R6 idle status
      '{1'b1, 1'b1, 32'h883C, D1, 4'b0001, D0, 4'd4},              // R4 core0 via bit15
      '{1'b0, 1'b1, 32'h082C, D0, 4'b0001, SW, 4'd6},              // R6 done set
      '{1'b1, 1'b1, 32'h683C, D1, 4'b0111, D0, 4'd4},              // R4 cores 1,2
      '{1'b1, 1'b1, 32'h483C, D0, 4'b0101, D0, 4'd5},              // R5 only core1 clears
      '{1'b0, 1'b1, 32'hF82C, D0, 4'b0101, D0, 4'd2},              // R2 masked status
      '{1'b1, 1'b1, 32'h183C, 64'h80FF_00FF_1234_5678, 4'b1101, D0, 4'd3}, // R3
      '{1'b0, 1'b1, 32'h382C, D0, 4'b1101, SW, 4'd2},              // R2 masked status, done
      '{1'b1, 1'b1, 32'h083C, D0, 4'b1101, D0, 4'd5},              // R5 no core selected
      '{1'b0, 1'b1, 32'h082C, D0, 4'b1101, D0, 4'd3},              // R3 done cleared
      '{1'b0, 1'b1, 32'h083C, D0, 4'b1101, ONES, 4'd7},            // R7 request offset read
      '{1'b1, 1'b1, 32'hF840, D1, 4'b1101, D0, 4'd7},              // R7 unimplemented write
      '{1'b0, 1'b1, 32'h082C, D0, 4'b1101, D0, 4'd7},              // R7 done untouched
      '{1'b0, 1'b1, 32'h1234, D0, 4'b1101, ONES, 4'd7},            // R7 unimplemented read
      '{1'b1, 1'b0, 32'hF83C, D0, 4'b1101, D0, 4'd8},              // R8 narrow write
      '{1'b0, 1'b0, 32'h082C, D0, 4'b1101, ONES, 4'd8},            // R8 narrow read
      '{1'b1, 1'b1, 32'hF83C, D0, 4'b0000, D0, 4'd4},              // R4 all cores clear
      '{1'b1, 1'b1, 32'h883C, 64'h7FFF_FFFF_FFFF_FFFF, 4'b0000, D0, 4'd3}, // R3 top bit only
      '{1'b0, 1'b1, 32'h082C, D0, 4'b0000, D0, 4'd6}               // R6
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_req = 1'b0, bus_we = 1'b0, bus_wide = 1'b1;
   logic [31:0] bus_off = '0;
   logic [63:0] bus_wdata = '0;
   logic        bus_rvalid;
   logic [63:0] bus_rdata;
   logic [3:0]  core_wake;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   quad_wakeup_regs u_quad_wakeup_regs (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
      .bus_wide(bus_wide), .bus_off(bus_off), .bus_wdata(bus_wdata),
      .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .core_wake(core_wake)
   );

   task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", rq, act, exp);
      end
   endtask

   // Drive one access at the falling edge, sample just after the next rising edge.
   task automatic access(input logic we, input logic wide, input logic [31:0] off,
                         input logic [63:0] wd);
      @(negedge clk);
      bus_req = 1'b1; bus_we = we; bus_wide = wide; bus_off = off; bus_wdata = wd;
      @(posedge clk); #1;
      bus_req = 1'b0;
   endtask

   task automatic finish_run;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      chk("R1 wake", 64'(core_wake), 64'h0);
      chk("R1 rvalid", 64'(bus_rvalid), 64'h0);
      @(negedge clk); rst_n = 1'b1;

      for (int k = 0; k < NV; k++) begin
         access(TBL[k].we, TBL[k].wide, TBL[k].off, TBL[k].wd);
         // R10 outputs follow the flags right after the accepting edge
         chk($sformatf("R%0d wake vec%0d", TBL[k].rq, k), 64'(core_wake), 64'(TBL[k].ew));
         // R9 response timing
         chk($sformatf("R%0d rvalid vec%0d", TBL[k].rq, k), 64'(bus_rvalid), 64'(!TBL[k].we));
         if (!TBL[k].we)
            chk($sformatf("R%0d rdata vec%0d", TBL[k].rq, k), bus_rdata, TBL[k].er);
      end

      // R9 idle cycle drops rvalid
      @(negedge clk); @(posedge clk); #1;
      chk("R9 idle rvalid", 64'(bus_rvalid), 64'h0);

      // R10 single core set, visible same edge
      access(1'b1, 1'b1, 32'h183C, D1);
      chk("R10 core3 wake", 64'(core_wake), 64'h8);

      // R1 reset mid-run clears flags and done
      access(1'b1, 1'b1, 32'hF83C, D1);
      chk("R1 pre-reset wake", 64'(core_wake), 64'hF);
      @(negedge clk); rst_n = 1'b0;
      @(posedge clk); #1;
      chk("R1 wake after reset", 64'(core_wake), 64'h0);
      @(negedge clk); rst_n = 1'b1;
      access(1'b0, 1'b1, 32'h082C, D0);
      chk("R1 done after reset", bus_rdata, 64'h0);

      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end
endmodule